// File: doc/BRIEF.md
# Interrupt Source Controller with Resend Tracking

This block keeps the state of a bank of interrupt sources and offers them one at a time to a presentation controller. Each source has a configured priority, target server and trigger type: message or level. It also has two presentation bits (presented P, queued Q), a masked-pending flag and a resend flag. Commands arrive one per cycle on a single command port: message or level trigger, end-of-interrupt, return of a displaced interrupt, level deassert, and resend scan. The block turns them into delivery requests on a valid/ready channel. Each request is then answered with a granted or refused reply.

Exactly one delivery attempt is in flight at a time. Sources with pending work are served lowest index first. A refused delivery is not lost. The source's resend flag is set, and a one-cycle mark tells the presenter to record this controller in its resend map. A later resend scan redelivers every flagged source.

Source numbers `BASE` to `BASE+NSRC-1` belong to this controller. Other numbers are dropped and counted as errors.

Top module: `isc_top`

## Requirements
- R1: A message trigger (cmd_op 0) sets P and moves the old P into Q. A delivery request follows only when P was clear before the trigger. A trigger while P is set only queues (Q=1) and sends nothing.
- R2: An end-of-interrupt (cmd_op 1) on a message source moves Q into P and clears Q. The source is delivered again exactly when the new P is set.
- R3: On a level source, a trigger (cmd_op 0) sets P and is delivered only if P was clear. End-of-interrupt (cmd_op 1) leaves P unchanged and redelivers when P is set. A level deassert (cmd_op 4) clears P. On a message source, a level deassert has no effect.
- R4: A delivery attempt on a source whose priority is 8'hFF (masked) sends no request and sets masked-pending. A later configuration write of an unmasked priority to that source delivers it exactly once.
- R5: A refused reply (rsp_grant 0) sets the source's resend flag. `resend_mark` is then high for exactly the one cycle after the reply; a granted reply leaves it low.
- R6: A resend scan (cmd_op 3) redelivers every source whose resend flag is set, in ascending index order, and clears those flags. Sources without the flag are not delivered.
- R7: A displaced-interrupt return (cmd_op 2) redelivers that source through the normal path. A return carrying the inter-processor number `IPI_NUM` is ignored and does not count as an error.
- R8: A trigger, end-of-interrupt, return or deassert whose number lies outside the controller's range sends nothing, and `err_count` increments by one.
- R9: The delivery channel holds `dlv_valid` and its payload stable until `dlv_ready`. No new request is offered before the reply to the previous one. The request carries `BASE`+index, the configured priority and the configured server.
- R10: After reset no request is offered, `err_count` is zero and every source is masked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | IDXW | Local source index to configure |
| cfg_pri | input | PRIW | Priority to write (8'hFF = masked) |
| cfg_srv | input | SRVW | Target server to write |
| cfg_lsi | input | 1 | 1 = level source, 0 = message source |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code (0 trigger, 1 EOI, 2 return, 3 scan, 4 deassert) |
| cmd_num | input | NUMW | Global source number of the command |
| dlv_valid | output | 1 | Delivery request offered |
| dlv_ready | input | 1 | Presenter takes the request |
| dlv_num | output | NUMW | Source number being delivered |
| dlv_pri | output | PRIW | Priority of that source |
| dlv_srv | output | SRVW | Target server of that source |
| rsp_valid | input | 1 | Reply to the accepted request |
| rsp_grant | input | 1 | 1 = granted, 0 = refused |
| resend_mark | output | 1 | Pulse: set this controller's resend-map bit |
| err_count | output | ERRW | Count of commands with unknown source numbers |

## Verification
The assertions assume a well-behaved presenter: `rsp_valid` comes only after a request has been taken and before the next one is offered, and at most one command arrives per cycle. The stimulus follows both rules. A delivery is answered only after its handshake completes, and commands and configuration writes are issued only while the block is idle. Random commands, numbers that are sometimes out of range or equal to the inter-processor number, masked priorities and refusals are mixed with directed sequences through the presentation states.

// File: rtl/isc_pkg.sv
package isc_pkg;
  typedef enum logic [2:0] {
    OP_TRIG   = 3'd0,
    OP_EOI    = 3'd1,
    OP_RETURN = 3'd2,
    OP_SCAN   = 3'd3,
    OP_LOWER  = 3'd4
  } isc_op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_OFFER,
    ST_AWAIT
  } isc_st_e;
endpackage

// File: rtl/isc_pick.sv
module isc_pick #(
  parameter int N    = 16,
  localparam int IW  = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  logic [IW-1:0] chain [N+1];
  assign chain[N] = '0;
  // lowest index wins: walk from the top down
  for (genvar i = N - 1; i >= 0; i--) begin : g_chain
    assign chain[i] = req[i] ? IW'(i) : chain[i+1];
  end
  assign idx = chain[0];
  assign any = |req;
endmodule

// File: rtl/isc_cfg.sv
module isc_cfg #(
  parameter int NSRC = 16,
  parameter int PRIW = 8,
  parameter int SRVW = 4,
  localparam int IW  = $clog2(NSRC)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic [IW-1:0]   widx,
  input  logic [PRIW-1:0] wpri,
  input  logic [SRVW-1:0] wsrv,
  input  logic            wlsi,
  input  logic [IW-1:0]   ridx,
  output logic [PRIW-1:0] rpri,
  output logic [SRVW-1:0] rsrv,
  output logic [NSRC-1:0] lsi
);
  logic [PRIW-1:0] pri_mem [NSRC];
  logic [SRVW-1:0] srv_mem [NSRC];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NSRC; i++) begin
        pri_mem[i] <= '1;
        srv_mem[i] <= '0;
      end
      lsi <= '0;
    end else if (we) begin
      pri_mem[widx] <= wpri;
      srv_mem[widx] <= wsrv;
      lsi[widx]     <= wlsi;
    end
  end

  assign rpri = pri_mem[ridx];
  assign rsrv = srv_mem[ridx];
endmodule

// File: rtl/isc_top.sv
module isc_top #(
  parameter int NSRC    = 16,
  parameter int NUMW    = 8,
  parameter int BASE    = 16,
  parameter int IPI_NUM = 2,
  parameter int PRIW    = 8,
  parameter int SRVW    = 4,
  parameter int ERRW    = 8,
  localparam int IDXW   = $clog2(NSRC)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfg_we,
  input  logic [IDXW-1:0] cfg_idx,
  input  logic [PRIW-1:0] cfg_pri,
  input  logic [SRVW-1:0] cfg_srv,
  input  logic            cfg_lsi,
  input  logic            cmd_valid,
  input  logic [2:0]      cmd_op,
  input  logic [NUMW-1:0] cmd_num,
  output logic            dlv_valid,
  input  logic            dlv_ready,
  output logic [NUMW-1:0] dlv_num,
  output logic [PRIW-1:0] dlv_pri,
  output logic [SRVW-1:0] dlv_srv,
  input  logic            rsp_valid,
  input  logic            rsp_grant,
  output logic            resend_mark,
  output logic [ERRW-1:0] err_count
);
  import isc_pkg::*;

  localparam logic [PRIW-1:0] MASKED = '1;
  localparam logic [NUMW:0]   LO     = (NUMW+1)'(BASE);
  localparam logic [NUMW:0]   HI     = (NUMW+1)'(BASE + NSRC);

  logic [NSRC-1:0] pbit, qbit, want, rsnd, mpend, lsi;
  logic [IDXW-1:0] sel, loc;
  logic            any;
  logic [PRIW-1:0] sel_pri;
  logic [SRVW-1:0] sel_srv;
  isc_st_e         st;
  logic [IDXW-1:0] cur;

  isc_cfg #(.NSRC(NSRC), .PRIW(PRIW), .SRVW(SRVW)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .widx(cfg_idx), .wpri(cfg_pri),
    .wsrv(cfg_srv), .wlsi(cfg_lsi), .ridx(sel), .rpri(sel_pri),
    .rsrv(sel_srv), .lsi(lsi)
  );

  isc_pick #(.N(NSRC)) u_pick (.req(want), .any(any), .idx(sel));

  // command decode
  logic in_rng, is_ipi, op_src, take, rsp_take;
  isc_op_e op;
  assign op      = isc_op_e'(cmd_op);
  assign in_rng  = ({1'b0, cmd_num} >= LO) && ({1'b0, cmd_num} < HI);
  assign is_ipi  = (cmd_num == NUMW'(IPI_NUM));
  assign loc     = IDXW'(cmd_num - NUMW'(BASE));
  assign op_src  = (op == OP_TRIG) || (op == OP_EOI) ||
                   (op == OP_RETURN) || (op == OP_LOWER);
  assign take    = (st == ST_IDLE) && any;
  assign rsp_take = (st == ST_AWAIT) && rsp_valid;

  // per-source flags
  always_ff @(posedge clk) begin
    if (rst) begin
      pbit <= '0; qbit <= '0; want <= '0; rsnd <= '0; mpend <= '0;
    end else begin
      if (take) begin
        want[sel] <= 1'b0;
        if (sel_pri == MASKED) mpend[sel] <= 1'b1;
      end
      if (cfg_we && cfg_pri != MASKED && mpend[cfg_idx]) begin
        mpend[cfg_idx] <= 1'b0;
        want[cfg_idx]  <= 1'b1;
      end
      if (cmd_valid && op == OP_SCAN) begin
        want <= want | rsnd;
        rsnd <= '0;
        if (take) want[sel] <= 1'b0;
      end
      if (rsp_take && !rsp_grant) rsnd[cur] <= 1'b1;
      if (cmd_valid && in_rng) begin
        unique case (op)
          OP_TRIG: begin
            pbit[loc] <= 1'b1;
            if (!lsi[loc]) qbit[loc] <= pbit[loc];
            if (!pbit[loc]) want[loc] <= 1'b1;
          end
          OP_EOI: begin
            if (lsi[loc]) begin
              if (pbit[loc]) want[loc] <= 1'b1;
            end else begin
              pbit[loc] <= qbit[loc];
              qbit[loc] <= 1'b0;
              if (qbit[loc]) want[loc] <= 1'b1;
            end
          end
          OP_RETURN: want[loc] <= 1'b1;
          OP_LOWER:  if (lsi[loc]) pbit[loc] <= 1'b0;
          default: ;
        endcase
      end
    end
  end

  // error counter for numbers owned by no source
  always_ff @(posedge clk) begin
    if (rst) err_count <= '0;
    else if (cmd_valid && op_src && !in_rng && !(op == OP_RETURN && is_ipi))
      err_count <= err_count + 1'b1;
  end

  // single in-flight delivery engine
  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      dlv_valid   <= 1'b0;
      dlv_num     <= '0;
      dlv_pri     <= '0;
      dlv_srv     <= '0;
      cur         <= '0;
      resend_mark <= 1'b0;
    end else begin
      resend_mark <= 1'b0;
      unique case (st)
        ST_IDLE: if (take && sel_pri != MASKED) begin
          dlv_valid <= 1'b1;
          dlv_num   <= NUMW'(BASE) + NUMW'(sel);
          dlv_pri   <= sel_pri;
          dlv_srv   <= sel_srv;
          cur       <= sel;
          st        <= ST_OFFER;
        end
        ST_OFFER: if (dlv_ready) begin
          dlv_valid <= 1'b0;
          st        <= ST_AWAIT;
        end
        ST_AWAIT: if (rsp_valid) begin
          resend_mark <= !rsp_grant;
          st          <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R9: request held with stable payload until taken
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    dlv_valid && !dlv_ready |=> dlv_valid && $stable(dlv_num) && $stable(dlv_pri));
  // R9: only owned numbers are ever offered
  a_r9_range: assert property (@(posedge clk) disable iff (rst)
    dlv_valid |-> ({1'b0, dlv_num} >= LO) && ({1'b0, dlv_num} < HI));
  // R4: a masked priority never reaches the presenter
  a_r4_no_masked: assert property (@(posedge clk) disable iff (rst)
    dlv_valid |-> dlv_pri != MASKED);
  // R5: the resend mark only follows a refusal
  a_r5_mark_cause: assert property (@(posedge clk) disable iff (rst)
    resend_mark |-> $past(rsp_valid && !rsp_grant));
  // R8: the error counter moves by at most one per cycle
  a_r8_err_step: assert property (@(posedge clk) disable iff (rst)
    err_count == $past(err_count) || err_count == $past(err_count) + 1'b1);
endmodule

// File: tb/sim_isc_top.sv
module sim_isc_top;
  localparam int NSRC = 16, NUMW = 8, BASE = 16, IPI = 2;
  localparam int PRIW = 8, SRVW = 4, ERRW = 8, IDXW = 4;

  logic clk = 0, rst = 1;
  logic cfg_we = 0, cfg_lsi = 0;
  logic [IDXW-1:0] cfg_idx = '0;
  logic [PRIW-1:0] cfg_pri = '0;
  logic [SRVW-1:0] cfg_srv = '0;
  logic cmd_valid = 0;
  logic [2:0] cmd_op = '0;
  logic [NUMW-1:0] cmd_num = '0;
  logic dlv_valid, dlv_ready = 0, rsp_valid = 0, rsp_grant = 0, resend_mark;
  logic [NUMW-1:0] dlv_num;
  logic [PRIW-1:0] dlv_pri;
  logic [SRVW-1:0] dlv_srv;
  logic [ERRW-1:0] err_count;

  always #2 clk = ~clk;

  isc_top u0 (.*);

  int checks = 0, errors = 0;
  bit done = 0;

  // reference state
  bit m_p[NSRC], m_q[NSRC], m_lsi[NSRC], m_rs[NSRC], m_mp[NSRC];
  int m_pri[NSRC], m_srv[NSRC];
  int m_err = 0;
  int expq[$];

  task automatic check(string r, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", r, act, exp);
    end
  endtask

  function automatic void attempt(int i);
    if (m_pri[i] == 255) m_mp[i] = 1;
    else expq.push_back(i);
  endfunction

  function automatic void model_cmd(int op, int num);
    int i;
    bit inr;
    inr = num >= BASE && num < BASE + NSRC;
    i = num - BASE;
    if (op == 3) begin
      for (int k = 0; k < NSRC; k++)
        if (m_rs[k]) begin m_rs[k] = 0; attempt(k); end
      return;
    end
    if (op > 4) return;
    if (!inr) begin
      if (!(op == 2 && num == IPI)) m_err++;
      return;
    end
    case (op)
      0: begin
        if (!m_p[i]) attempt(i);
        if (!m_lsi[i]) m_q[i] = m_p[i];
        m_p[i] = 1;
      end
      1: if (m_lsi[i]) begin
        if (m_p[i]) attempt(i);
      end else begin
        m_p[i] = m_q[i]; m_q[i] = 0;
        if (m_p[i]) attempt(i);
      end
      2: attempt(i);
      4: if (m_lsi[i]) m_p[i] = 0;
      default: ;
    endcase
  endfunction

  // serve every expected delivery; g: 0 refuse, 1 grant, 2 random
  task automatic serve(string r, int g);
    while (expq.size() > 0) begin
      int idx, w;
      bit gr;
      idx = expq.pop_front();
      w = 0;
      while (!dlv_valid && w < 40) begin @(negedge clk); w++; end
      if (!dlv_valid) begin check({r, " R9 request timeout"}, 0, 1); return; end
      check({r, " R9 number"}, dlv_num, BASE + idx);
      check({r, " R9 priority"}, dlv_pri, m_pri[idx]);
      check({r, " R9 server"}, dlv_srv, m_srv[idx]);
      repeat ($urandom_range(0, 2)) @(negedge clk);
      check({r, " R9 held"}, dlv_valid, 1);
      dlv_ready = 1;
      @(negedge clk);
      dlv_ready = 0;
      gr = (g == 2) ? 1'($urandom_range(0, 1)) : 1'(g);
      rsp_valid = 1; rsp_grant = gr;
      @(negedge clk);
      rsp_valid = 0;
      check({r, " R5 resend mark"}, resend_mark, !gr);
      if (!gr) m_rs[idx] = 1;
    end
    for (int k = 0; k < 8; k++) @(negedge clk);
    check({r, " no extra request"}, dlv_valid, 0);
  endtask

  task automatic cmd(string r, int op, int num, int g);
    cmd_valid = 1; cmd_op = 3'(op); cmd_num = NUMW'(num);
    @(negedge clk);
    cmd_valid = 0;
    model_cmd(op, num);
    serve(r, g);
    check({r, " R8 err_count"}, err_count, m_err);
  endtask

  task automatic cfg(string r, int i, int pri, int srv, bit l, int g);
    cfg_we = 1; cfg_idx = IDXW'(i); cfg_pri = PRIW'(pri);
    cfg_srv = SRVW'(srv); cfg_lsi = l;
    @(negedge clk);
    cfg_we = 0;
    m_pri[i] = pri; m_srv[i] = srv; m_lsi[i] = l;
    if (m_mp[i] && pri != 255) begin m_mp[i] = 0; expq.push_back(i); end
    serve(r, g);
  endtask

  initial begin
    for (int k = 0; k < NSRC; k++) begin
      m_pri[k] = 255; m_srv[k] = 0;
    end
    void'($urandom(32'd7177));
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R10 reset valid", dlv_valid, 0);
    check("R10 reset err", err_count, 0);
    check("R10 reset mark", resend_mark, 0);
    // R10: all masked after reset, trigger sends nothing
    cmd("R10 masked at reset", 0, BASE + 1, 1);

    cfg("cfg", 3, 5, 2, 0, 1);
    cmd("R1 first trigger", 0, BASE + 3, 1);
    cmd("R1 trigger queues", 0, BASE + 3, 1);
    cmd("R2 eoi moves Q", 1, BASE + 3, 1);
    cmd("R2 eoi empties", 1, BASE + 3, 1);

    cfg("cfg", 6, 9, 7, 1, 1);
    cmd("R3 level trigger", 0, BASE + 6, 1);
    cmd("R3 level eoi while P", 1, BASE + 6, 1);
    cmd("R3 level deassert", 4, BASE + 6, 1);
    cmd("R3 eoi after deassert", 1, BASE + 6, 1);
    cmd("R3 deassert on message ignored", 4, BASE + 3, 1);
    cmd("R3 trigger after ignored deassert", 0, BASE + 3, 1);

    cmd("R4 masked trigger", 0, BASE + 1, 1);
    cfg("R4 unmask delivers", 1, 4, 1, 0, 1);

    cfg("cfg", 9, 3, 3, 0, 1);
    cmd("R5 refused", 2, BASE + 9, 0);
    cmd("R5 refused second", 2, BASE + 6, 0);
    cmd("R6 scan ascending", 3, 0, 1);
    cmd("R6 scan with nothing flagged", 3, 0, 1);

    cmd("R7 return redelivers", 2, BASE + 3, 1);
    cmd("R7 IPI return ignored", 2, IPI, 1);
    cmd("R8 out of range trigger", 0, BASE + NSRC, 1);
    cmd("R8 below range eoi", 1, 5, 1);

    for (int n = 0; n < 300; n++) begin
      int r, num;
      r = $urandom_range(0, 19);
      num = ($urandom_range(0, 9) == 0) ? $urandom_range(0, 63) : BASE + $urandom_range(0, NSRC - 1);
      if (r < 3)
        cfg("rand cfg", $urandom_range(0, NSRC - 1),
            ($urandom_range(0, 3) == 0) ? 255 : $urandom_range(0, 254),
            $urandom_range(0, 15), 1'($urandom_range(0, 1)), 2);
      else
        cmd("rand cmd", (r < 19) ? $urandom_range(0, 4) : 3, num, 2);
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      end
    join_any
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule